// File: doc/BRIEF.md
# Trigger-Line Reset Detector

This block watches a trigger line that normally carries short trigger pulses and treats an unusually long high level on it as a command to reset the device. The line is first brought into the local clock domain through a flip-flop chain. While it is held high, a counter measures how many consecutive samples have been high. Once that count goes past a configured threshold, the reset output turns on and stays on for as long as the line stays high.

When the line drops, the reset output is kept on for a long, configurable hold-off interval so that downstream clock recovery logic can re-lock before the device starts listening again. If the line goes high again during the hold-off, the hold-off is cancelled. It starts from zero at the next low level. Short pulses reach the trigger output with a fixed two-cycle delay. The trigger output is forced low whenever the reset output is on, so nothing on the link is acted upon during reset.

The default threshold is 100 cycles and the default hold-off is 5,000,000 cycles. At a 100 MHz clock these are 1 us and 50 ms.

Top module: `line_reset_monitor`

## Requirements
- R1: When `trig_i` is sampled high on more than `HIGH_LIMIT` consecutive rising edges (that is, on `HIGH_LIMIT+1` of them), `rst_o` goes high. It does so at the second rising edge after the last of those samples.
- R2: A high run of `HIGH_LIMIT` or fewer samples never asserts `rst_o`. A single low sample clears the run, so two such runs separated by one low sample cause no reset.
- R3: Once `rst_o` is high, it stays high for as long as `trig_i` stays high.
- R4: After the line is released, `rst_o` goes low at exactly the `HOLD_CYCLES+2`-th rising edge after the edge that first samples `trig_i` low. It stays high until then, provided the line stays low.
- R5: A high sample during the hold-off keeps `rst_o` high. The hold-off count then restarts in full from the next low sample.
- R6: While `rst_o` is low after an edge, `trig_o` after that edge equals the value of `trig_i` sampled two rising edges earlier.
- R7: `trig_o` is low whenever `rst_o` is high.
- R8: While `rst_ni` is low (asynchronous, active low), `rst_o` and `trig_o` are low and the synchroniser, run counter and hold-off timer are cleared. This applies even if a line-triggered reset was in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all logic on the rising edge |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| trig_i | input | 1 | Raw trigger line, asynchronous to `clk_i` |
| rst_o | output | 1 | Reset request derived from the trigger line, active high |
| trig_o | output | 1 | Synchronised trigger, gated low during reset |

## Verification
The following properties are checked by assertions on every cycle:
- entry into reset only from a run count at the threshold with the line high;
- no entry while the run is shorter;
- reset held while the line is high;
- release only when the hold-off timer is at its last count with the line low;
- the timer staying inside its range;
- the trigger output being low during reset;
- every edge of the trigger output matching the input three samples earlier.

Other behaviours can only be shown by the bench's scenarios:
- the exact cycle of release after a full hold-off;
- that a re-raised line restarts the whole hold-off;
- that two sub-threshold runs split by one low sample do not add up;
- the effect of power-on reset in the middle of a line-triggered reset.

// File: rtl/lrm_pkg.sv
`timescale 1ns/1ps
package lrm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HELD = 2'd1,
        ST_HOLD = 2'd2
    } lrm_state_e;

    typedef struct packed {
        lrm_state_e state;
        logic       trig_out;
    } lrm_ctrl_t;

endpackage

// File: rtl/lrm_sync.sv
`timescale 1ns/1ps
module lrm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lrm_run_counter.sv
`timescale 1ns/1ps
module lrm_run_counter #(
    parameter int LIMIT = 100,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          level_i,
    output logic          hit_o,
    output logic [CW-1:0] count_o
);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] count_d, count_q;

    // Counts consecutive high samples; saturates at the limit.
    always_comb begin
        count_d = count_q;
        if (clear_i || !level_i) begin
            count_d = '0;
        end else if (count_q != LIM_V) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) count_q <= '0;
        else         count_q <= count_d;
    end

    assign hit_o   = level_i && (count_q == LIM_V);
    assign count_o = count_q;
endmodule

// File: rtl/lrm_hold_timer.sv
`timescale 1ns/1ps
module lrm_hold_timer #(
    parameter int CYCLES = 5_000_000,
    localparam int TW = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          run_i,
    output logic          done_o,
    output logic [TW-1:0] count_o
);
    localparam logic [TW-1:0] LAST_V = TW'(CYCLES - 1);

    logic [TW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (start_i) begin
            count_d = '0;
        end else if (run_i) begin
            count_d = (count_q == LAST_V) ? '0 : count_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) count_q <= '0;
        else         count_q <= count_d;
    end

    assign done_o  = run_i && (count_q == LAST_V);
    assign count_o = count_q;
endmodule

// File: rtl/line_reset_monitor.sv
`timescale 1ns/1ps
module line_reset_monitor
    import lrm_pkg::*;
#(
    parameter int HIGH_LIMIT  = 100,
    parameter int HOLD_CYCLES = 5_000_000,
    parameter int SYNC_STAGES = 2,
    localparam int RUN_W  = $clog2(HIGH_LIMIT + 1),
    localparam int HOLD_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic rst_o,
    output logic trig_o
);
    logic              trig_s;
    logic              run_hit;
    logic [RUN_W-1:0]  run_count;
    logic              hold_start, hold_run, hold_done;
    logic [HOLD_W-1:0] hold_count;
    lrm_ctrl_t         ctrl_d, ctrl_q;

    lrm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (trig_i),
        .q_o    (trig_s)
    );

    lrm_run_counter #(.LIMIT(HIGH_LIMIT)) u_run (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (ctrl_q.state != ST_IDLE),
        .level_i (trig_s),
        .hit_o   (run_hit),
        .count_o (run_count)
    );

    assign hold_start = (ctrl_q.state == ST_HELD);
    assign hold_run   = (ctrl_q.state == ST_HOLD) && !trig_s;

    lrm_hold_timer #(.CYCLES(HOLD_CYCLES)) u_hold (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (hold_start),
        .run_i   (hold_run),
        .done_o  (hold_done),
        .count_o (hold_count)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.state)
            ST_IDLE: if (run_hit)   ctrl_d.state = ST_HELD;
            ST_HELD: if (!trig_s)   ctrl_d.state = ST_HOLD;
            ST_HOLD: begin
                if (trig_s)         ctrl_d.state = ST_HELD;
                else if (hold_done) ctrl_d.state = ST_IDLE;
            end
            default:                ctrl_d.state = ST_IDLE;
        endcase
        ctrl_d.trig_out = trig_s && (ctrl_d.state == ST_IDLE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q.state    <= ST_IDLE;
            ctrl_q.trig_out <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign rst_o  = (ctrl_q.state != ST_IDLE);
    assign trig_o = ctrl_q.trig_out;
endmodule

// File: rtl/lrm_checker.sv
`timescale 1ns/1ps
module lrm_checker #(
    parameter int HIGH_LIMIT  = 100,
    parameter int HOLD_CYCLES = 5_000_000,
    localparam int RUN_W  = $clog2(HIGH_LIMIT + 1),
    localparam int HOLD_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              trig_i,
    input logic              trig_s,
    input logic [RUN_W-1:0]  run_count,
    input logic [HOLD_W-1:0] hold_count,
    input logic              rst_o,
    input logic              trig_o
);
    p_entry_after_run_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_o) |-> ($past(trig_s) && ($past(run_count) == RUN_W'(HIGH_LIMIT))));

    p_no_short_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rst_o && (run_count < RUN_W'(HIGH_LIMIT))) |=> !rst_o);

    p_held_while_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_o && trig_s) |=> rst_o);

    p_release_after_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_o) |-> (!$past(trig_s) && ($past(hold_count) == HOLD_W'(HOLD_CYCLES - 1))));

    p_hold_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(hold_count) < HOLD_CYCLES);

    p_rise_follows_input_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(trig_o) |-> $past(trig_i, 3));

    p_fall_follows_input_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(trig_o) && !rst_o) |-> !$past(trig_i, 3));

    p_gated_in_reset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_o |-> !trig_o);
endmodule

bind line_reset_monitor lrm_checker #(
    .HIGH_LIMIT  (HIGH_LIMIT),
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .trig_s     (trig_s),
    .run_count  (run_count),
    .hold_count (hold_count),
    .rst_o      (rst_o),
    .trig_o     (trig_o)
);

// File: tb/line_reset_monitor_tb_top.sv
`timescale 1ns/1ps
module line_reset_monitor_tb_top;
    localparam int LIM  = 10;
    localparam int HOLD = 40;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic trig = 1'b0;
    logic rst_out, trig_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    line_reset_monitor #(.HIGH_LIMIT(LIM), .HOLD_CYCLES(HOLD)) dut_i (
        .clk_i  (clk),
        .rst_ni (por_n),
        .trig_i (trig),
        .rst_o  (rst_out),
        .trig_o (trig_out)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements: two-edge input delay,
    // run threshold, hold-off length and restart rule.
    bit    p1, p2, ds;
    bit    m_inr, prev_inr, m_rearm, m_exp_trig;
    int    m_run, m_rel;
    string m_lbl = "R8";

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            p1 = 0; p2 = 0; m_inr = 0; m_run = 0; m_rel = 0; m_rearm = 0;
            m_exp_trig = 0; m_lbl = "R8";
        end else begin
            ds = p2; p2 = p1; p1 = trig;
            prev_inr = m_inr;
            if (!m_inr) begin
                if (ds) begin
                    if (m_run == LIM) begin m_inr = 1; m_rel = 0; m_run = 0; end
                    else m_run++;
                end else m_run = 0;
            end else begin
                if (ds) begin
                    if (m_rel > 0) m_rearm = 1;
                    m_rel = 0;
                end else begin
                    m_rel++;
                    if (m_rel == HOLD + 1) begin
                        m_inr = 0; m_rel = 0; m_run = 0; m_rearm = 0;
                    end
                end
            end
            m_exp_trig = m_inr ? 1'b0 : ds;
            if (m_inr && !prev_inr)      m_lbl = "R1";
            else if (!m_inr && prev_inr) m_lbl = "R4";
            else if (m_inr && m_rearm)   m_lbl = "R5";
            else if (m_inr && ds)        m_lbl = "R3";
            else if (m_inr)              m_lbl = "R4";
            else                         m_lbl = "R2";
        end
    end

    always @(negedge clk) begin
        if (por_n && !finished) begin
            check(m_lbl, int'(rst_out), int'(m_inr));
            check(m_inr ? "R7" : "R6", int'(trig_out), int'(m_exp_trig));
        end
    end

    task automatic drive(input bit v, input int n);
        trig = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        check("R8", int'(rst_out), 0);
        check("R8", int'(trig_out), 0);
        por_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: run exactly at the limit
        drive(1, LIM); drive(0, 6);
        check("R2", int'(rst_out), 0);

        // R1: one sample more than the limit
        drive(1, LIM + 1); drive(0, 3);
        check("R1", int'(rst_out), 1);
        drive(0, HOLD + 4);
        check("R4", int'(rst_out), 0);

        // R2: two limit-length runs split by one low sample
        drive(1, LIM); drive(0, 1); drive(1, LIM); drive(0, 6);
        check("R2", int'(rst_out), 0);

        // R3 and R5: long hold, release, re-raise during hold-off
        drive(1, LIM + 20);
        check("R3", int'(rst_out), 1);
        drive(0, HOLD - 10); drive(1, 3); drive(0, HOLD - 5);
        check("R5", int'(rst_out), 1);
        drive(0, 20);
        check("R5", int'(rst_out), 0);

        // R8: power-on reset during a line-triggered reset
        drive(1, LIM + 4); drive(0, 3);
        check("R8", int'(rst_out), 1);
        por_n = 1'b0;
        @(negedge clk);
        check("R8", int'(rst_out), 0);
        check("R8", int'(trig_out), 0);
        por_n = 1'b1;
        drive(0, 4);

        // Random pulse trains around the threshold
        for (int i = 0; i < 160; i++) begin
            int len, gap;
            len = 1 + int'($urandom_range(2 * LIM + 4));
            gap = ($urandom_range(3) == 0) ? 1 + int'($urandom_range(HOLD + 10))
                                           : 1 + int'($urandom_range(6));
            drive(1, len);
            drive(0, gap);
        end
        drive(0, HOLD + 10);
        check("R4", int'(rst_out), 0);
        finish_run();
    end
endmodule